// File: doc/BRIEF.md
# SPI Ethernet Transmit Chunk Framer

This block turns an outgoing Ethernet frame into the fixed-size data chunks that a MAC-PHY accepts over a serial peripheral link. Frame bytes arrive on a ready/valid byte stream. The first byte carries a start marker and the total frame length. The block fills a 64-byte chunk buffer and then shifts out one 68-byte chunk inside a single chip-select window. Each chunk is a 32-bit header followed by the 64-byte payload. The header holds start and end flags, the offset of the last frame byte and an odd-parity bit. Unused payload bytes in the final chunk are sent as zero.

Before the block commits to a frame, it reads the transmit credit count from a buffer status word. If the frame needs more chunks than there are credits, the block still consumes the frame but sends nothing. While a chunk is shifting, the block collects the bytes returned by the PHY. The last four of those bytes form a receive footer. The block presents the footer and flags a pending receive when the footer reports available receive chunks.

Top module: `spi_tx_chunker`

## Requirements
- R1: Each chunk is exactly 68 byte transfers: 4 header bytes, most significant byte first, then 64 payload bytes. `spi_cs_n` stays low from the first byte to the last and is high outside chunks.
- R2: Every header has bit 31 (data chunk) and bit 21 (data valid) set. Bits 30:22, 19:15 and 7:1 are zero.
- R3: Header bit 20 (start) is set only in the chunk holding the first frame byte.
- R4: Header bit 14 (end) is set only in the chunk holding the last frame byte. In that chunk, bits 13:8 hold the payload index of the last frame byte. In all other chunks bits 13:8 are zero.
- R5: Header bit 0 is set so that the 32-bit header contains an odd number of ones.
- R6: Payload bytes carry the frame bytes in order. Every payload position after the last frame byte is sent as 8'h00.
- R7: The credit count is bits 15:8 of `buf_status`, sampled with the start byte. The frame is sent only if ceil(length/64) does not exceed the credit count. Otherwise all its bytes are accepted and discarded with no chunk and no chip-select activity.
- R8: One cycle after the last byte of a chunk transfers, `footer_vld` pulses for one cycle. At the same time `footer` holds the last four received bytes, big-endian, with the first of the four in bits 31:24.
- R9: `rx_pend` pulses together with `footer_vld` exactly when footer bits 28:24 (receive chunks available) are nonzero.
- R10: `in_ready` is low whenever `spi_cs_n` is low.
- R11: A frame of 1 to 64 bytes goes out as one chunk with both start and end flags set.
- R12: After reset, `spi_cs_n` is high and `in_ready`, `sh_valid`, `footer_vld` and `rx_pend` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Frame byte accepted |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| in_len | input | LEN_W | Frame length in bytes, valid with the start byte |
| buf_status | input | 32 | Buffer status word, credits in bits 15:8 |
| spi_cs_n | output | 1 | Chip select, low during a chunk |
| sh_valid | output | 1 | Byte shifter request |
| sh_ready | input | 1 | Byte shifter takes `sh_data` and returns `sh_rx` |
| sh_data | output | 8 | Byte to shift out |
| sh_rx | input | 8 | Byte shifted in during the same transfer |
| footer | output | 32 | Last captured receive footer |
| footer_vld | output | 1 | One-cycle strobe for a new footer |
| rx_pend | output | 1 | Receive chunks pending, qualifies the footer strobe |

## Verification
The bench sends frames whose lengths fall on the chunk edges: 1, 64, 65, 128 and 130 bytes. With these it checks that start and end flags land in the right chunk and that the end offset is 0 or 63 where it must be. A design off by one in its byte counter would split a 64-byte frame into two chunks or write a wrong end offset. The bench also checks zero padding after short tails, since a design that reuses stale buffer contents would leak bytes from the previous frame. It offers frames with a credit count one short of what they need, and with exactly enough. A comparison off by one would either send a frame that must be dropped or drop one that fits. The shifter stalls at irregular points, so a buffer read that runs ahead of the transfer handshake would show up as shifted payload. Footers alternate between zero and nonzero receive counts, so the pending flag is checked both ways.

// File: rtl/txchunk_pkg.sv
`timescale 1ns/1ps
package txchunk_pkg;

  localparam int HDR_BYTES = 4;
  localparam int HDR_W     = 32;

  // header bit positions decoded by the PHY
  localparam int BIT_DNC = 31;
  localparam int BIT_DV  = 21;
  localparam int BIT_SV  = 20;
  localparam int BIT_EV  = 14;
  localparam int EBO_LSB = 8;
  localparam int EBO_W   = 6;
  localparam int BIT_P   = 0;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_SHIFT,
    ST_DROP
  } chunk_st_t;

  // parity bit giving an odd count of ones over the whole word
  function automatic logic odd_fill(input logic [HDR_W-1:1] v);
    return ~(^v);
  endfunction

endpackage

// File: rtl/tx_chunk_ram.sv
`timescale 1ns/1ps
module tx_chunk_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rq
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rq <= mem[ra];
  end

endmodule

// File: rtl/tx_chunk_hdr.sv
`timescale 1ns/1ps
module tx_chunk_hdr
  import txchunk_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             first,
  input  logic             last,
  input  logic [AW-1:0]    ebo,
  output logic [HDR_W-1:0] hdr
);

  logic [HDR_W-1:0] nxt;

  always_comb begin
    nxt = '0;
    nxt[BIT_DNC] = 1'b1;
    nxt[BIT_DV]  = 1'b1;
    nxt[BIT_SV]  = first;
    nxt[BIT_EV]  = last;
    if (last) nxt[EBO_LSB +: EBO_W] = EBO_W'(ebo);
    nxt[BIT_P] = odd_fill(nxt[HDR_W-1:1]);
  end

  always_ff @(posedge clk) begin
    if (rst)       hdr <= '0;
    else if (load) hdr <= nxt;
  end

  assert_hdr_odd_R5: assert property (@(posedge clk) disable iff (rst)
    $past(load) |-> ($countones(hdr) % 2 == 1));

  assert_hdr_fixed_R2: assert property (@(posedge clk) disable iff (rst)
    $past(load) |-> (hdr[BIT_DNC] && hdr[BIT_DV]));

endmodule

// File: rtl/tx_footer_cap.sv
`timescale 1ns/1ps
module tx_footer_cap #(
  parameter int RCA_LSB = 24,
  parameter int RCA_W   = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_stb,
  input  logic        rx_last,
  input  logic [7:0]  rx_byte,
  output logic [31:0] footer,
  output logic        footer_vld,
  output logic        rx_pend
);

  logic [23:0] sr;
  logic [31:0] word;

  assign word = {sr, rx_byte};

  always_ff @(posedge clk) begin
    if (rst) begin
      sr         <= '0;
      footer     <= '0;
      footer_vld <= 1'b0;
      rx_pend    <= 1'b0;
    end else begin
      footer_vld <= 1'b0;
      rx_pend    <= 1'b0;
      if (rx_stb) begin
        sr <= word[23:0];
        if (rx_last) begin
          footer     <= word;
          footer_vld <= 1'b1;
          rx_pend    <= |word[RCA_LSB +: RCA_W];
        end
      end
    end
  end

  assert_pend_with_footer_R9: assert property (@(posedge clk) disable iff (rst)
    rx_pend |-> footer_vld);

endmodule

// File: rtl/spi_tx_chunker.sv
`timescale 1ns/1ps
module spi_tx_chunker
  import txchunk_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 64,
  parameter int LEN_W         = 11,
  parameter int CREDIT_LSB    = 8,
  parameter int CREDIT_W      = 8,
  parameter int RCA_LSB       = 24,
  parameter int RCA_W         = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [LEN_W-1:0] in_len,
  input  logic [31:0]      buf_status,
  output logic             spi_cs_n,
  output logic             sh_valid,
  input  logic             sh_ready,
  output logic [7:0]       sh_data,
  input  logic [7:0]       sh_rx,
  output logic [31:0]      footer,
  output logic             footer_vld,
  output logic             rx_pend
);

  localparam int CHUNK_BYTES = PAYLOAD_BYTES + HDR_BYTES;
  localparam int AW          = $clog2(PAYLOAD_BYTES);
  localparam int IDX_W       = $clog2(CHUNK_BYTES);
  localparam logic [31:0] CREDIT_MASK = ((32'd1 << CREDIT_W) - 32'd1) << CREDIT_LSB;

  chunk_st_t        state;
  logic [LEN_W-1:0] len_rem;
  logic             first_q;
  logic             last_q;
  logic [AW:0]      fill_cnt;
  logic [AW:0]      chunk_bytes;
  logic [IDX_W-1:0] sh_idx;

  logic [LEN_W:0]    need;
  logic [CREDIT_W-1:0] cred_now;
  logic              credit_ok;
  logic              in_fire;
  logic              sh_xfer;
  logic              last_idx;
  logic              frame_end;
  logic              chunk_full;
  logic              close_chunk;
  logic [IDX_W-1:0]  rd_idx;
  logic [AW-1:0]     rd_addr;
  logic [IDX_W-1:0]  pay_idx;
  logic [7:0]        ram_q;
  logic [HDR_W-1:0]  hdr_q;
  logic              unused_status;

  assign unused_status = ^(buf_status & ~CREDIT_MASK);

  // credit gate: chunks needed versus credits granted
  assign need      = ({1'b0, in_len} + (LEN_W+1)'(PAYLOAD_BYTES - 1)) >> AW;
  assign cred_now  = buf_status[CREDIT_LSB +: CREDIT_W];
  assign credit_ok = (32'(need) <= 32'(cred_now)) && (in_len != '0);

  assign in_fire     = in_valid && in_ready;
  assign sh_xfer     = sh_valid && sh_ready;
  assign last_idx    = (sh_idx == IDX_W'(CHUNK_BYTES - 1));
  assign frame_end   = (len_rem == LEN_W'(1)) || in_eof;
  assign chunk_full  = (fill_cnt == (AW+1)'(PAYLOAD_BYTES - 1));
  assign close_chunk = (state == ST_FILL) && in_fire && (frame_end || chunk_full);

  always_comb begin
    case (state)
      ST_IDLE:  in_ready = in_valid && !in_sof;
      ST_FILL:  in_ready = 1'b1;
      ST_DROP:  in_ready = 1'b1;
      default:  in_ready = 1'b0;
    endcase
  end

  assign spi_cs_n = (state != ST_SHIFT);
  assign sh_valid = (state == ST_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      len_rem     <= '0;
      first_q     <= 1'b0;
      last_q      <= 1'b0;
      fill_cnt    <= '0;
      chunk_bytes <= '0;
      sh_idx      <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (in_valid && in_sof) begin
            len_rem <= in_len;
            if (credit_ok) begin
              state    <= ST_FILL;
              first_q  <= 1'b1;
              fill_cnt <= '0;
            end else begin
              state <= ST_DROP;
            end
          end
        end
        ST_FILL: begin
          if (in_fire) begin
            len_rem  <= len_rem - LEN_W'(1);
            fill_cnt <= fill_cnt + (AW+1)'(1);
            if (frame_end || chunk_full) begin
              state       <= ST_SHIFT;
              last_q      <= frame_end;
              chunk_bytes <= fill_cnt + (AW+1)'(1);
              sh_idx      <= '0;
            end
          end
        end
        ST_SHIFT: begin
          if (sh_xfer) begin
            if (last_idx) begin
              sh_idx   <= '0;
              fill_cnt <= '0;
              first_q  <= 1'b0;
              state    <= last_q ? ST_IDLE : ST_FILL;
            end else begin
              sh_idx <= sh_idx + IDX_W'(1);
            end
          end
        end
        default: begin
          if (in_fire) begin
            len_rem <= len_rem - LEN_W'(1);
            if (frame_end) state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // read one byte ahead of the transfer so the registered RAM output lines up
  assign rd_idx  = sh_xfer ? (sh_idx + IDX_W'(1)) : sh_idx;
  assign rd_addr = AW'(rd_idx - IDX_W'(HDR_BYTES));
  assign pay_idx = sh_idx - IDX_W'(HDR_BYTES);

  tx_chunk_ram #(.DEPTH(PAYLOAD_BYTES), .DW(8)) u_ram (
    .clk (clk),
    .we  ((state == ST_FILL) && in_fire),
    .wa  (fill_cnt[AW-1:0]),
    .wd  (in_data),
    .ra  (rd_addr),
    .rq  (ram_q)
  );

  tx_chunk_hdr #(.AW(AW)) u_hdr (
    .clk   (clk),
    .rst   (rst),
    .load  (close_chunk),
    .first (first_q),
    .last  (frame_end),
    .ebo   (fill_cnt[AW-1:0]),
    .hdr   (hdr_q)
  );

  always_comb begin
    if (sh_idx < IDX_W'(HDR_BYTES)) begin
      case (sh_idx[1:0])
        2'd0:    sh_data = hdr_q[31:24];
        2'd1:    sh_data = hdr_q[23:16];
        2'd2:    sh_data = hdr_q[15:8];
        default: sh_data = hdr_q[7:0];
      endcase
    end else if (pay_idx < IDX_W'(chunk_bytes)) begin
      sh_data = ram_q;
    end else begin
      sh_data = 8'h00;
    end
  end

  tx_footer_cap #(.RCA_LSB(RCA_LSB), .RCA_W(RCA_W)) u_foot (
    .clk        (clk),
    .rst        (rst),
    .rx_stb     (sh_xfer),
    .rx_last    (last_idx),
    .rx_byte    (sh_rx),
    .footer     (footer),
    .footer_vld (footer_vld),
    .rx_pend    (rx_pend)
  );

  assert_stall_in_chunk_R10: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> !in_ready);

  assert_cs_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!spi_cs_n && !(sh_xfer && last_idx)) |=> !spi_cs_n);

  assert_idx_range_R1: assert property (@(posedge clk) disable iff (rst)
    sh_idx <= IDX_W'(CHUNK_BYTES - 1));

  assert_footer_after_last_R8: assert property (@(posedge clk) disable iff (rst)
    footer_vld |-> $past(sh_xfer && last_idx));

  assert_ebo_only_at_end_R4: assert property (@(posedge clk) disable iff (rst)
    (sh_valid && !hdr_q[BIT_EV]) |-> (hdr_q[EBO_LSB +: EBO_W] == '0));

  assert_start_first_only_R3: assert property (@(posedge clk) disable iff (rst)
    (sh_valid && hdr_q[BIT_SV]) |-> first_q);

endmodule

// File: tb/spi_tx_chunker_tb.sv
`timescale 1ns/1ps
module spi_tx_chunker_tb;

  localparam int LEN_W = 11;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [7:0]       in_data = '0;
  logic             in_sof = 1'b0;
  logic             in_eof = 1'b0;
  logic [LEN_W-1:0] in_len = '0;
  logic [31:0]      buf_status = '0;
  logic             spi_cs_n;
  logic             sh_valid;
  logic             sh_ready = 1'b0;
  logic [7:0]       sh_data;
  logic [7:0]       sh_rx = '0;
  logic [31:0]      footer;
  logic             footer_vld;
  logic             rx_pend;

  always #4 clk = ~clk;

  spi_tx_chunker #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_len(in_len),
    .buf_status(buf_status), .spi_cs_n(spi_cs_n), .sh_valid(sh_valid),
    .sh_ready(sh_ready), .sh_data(sh_data), .sh_rx(sh_rx), .footer(footer),
    .footer_vld(footer_vld), .rx_pend(rx_pend)
  );

  logic [7:0] exp_q[$];
  int checks = 0;
  int fails = 0;
  int exp_chunks = 0;
  int got_chunks = 0;
  int r1_bad = 0;
  int r10_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic logic [7:0] frame_byte(int f, int k);
    return 8'(f * 37 + k * 5 + 1);
  endfunction

  function automatic logic [31:0] ref_hdr(bit sv, bit ev, int ebo);
    logic [31:0] h;
    h = 32'h8020_0000;
    if (sv) h[20] = 1'b1;
    if (ev) begin
      h[14] = 1'b1;
      h[13:8] = 6'(ebo);
    end
    h[0] = ($countones(h) % 2 == 0);
    return h;
  endfunction

  function automatic logic [31:0] ref_footer(int n);
    return {3'b000, 5'(n % 3), 8'h12, 8'(n), 8'h3C};
  endfunction

  // driver: push the expected chunk bytes, then feed the frame
  task automatic send_frame(input int f, input int len, input int cred);
    int need;
    need = (len + 63) / 64;
    if (need <= cred) begin
      for (int c = 0; c < need; c++) begin
        int n;
        logic [31:0] h;
        n = (len - 64 * c > 64) ? 64 : len - 64 * c;
        h = ref_hdr(c == 0, c == need - 1, n - 1);
        for (int b = 3; b >= 0; b--) exp_q.push_back(h[8*b +: 8]);
        for (int i = 0; i < 64; i++)
          exp_q.push_back(i < n ? frame_byte(f, 64 * c + i) : 8'h00);
        exp_chunks++;
      end
    end
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid   = 1'b1;
      in_sof     = (k == 0);
      in_eof     = (k == len - 1);
      in_data    = frame_byte(f, k);
      in_len     = LEN_W'(len);
      buf_status = 32'hA5A5_00C3 | (32'(cred) << 8);
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eof   = 1'b0;
  endtask

  // monitor: shifter model plus scoreboard
  initial begin
    logic [7:0]  got [68];
    logic [7:0]  e [68];
    logic [31:0] fexp;
    bit          fpend;
    bit          prev_cs_n;
    int          bidx;
    int          cyc;
    fpend = 1'b0;
    prev_cs_n = 1'b1;
    bidx = 0;
    cyc = 0;
    fexp = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst) begin
        if (fpend) begin
          chk(footer_vld && footer == fexp, "R8", "footer word", footer, fexp);
          chk(rx_pend == (fexp[28:24] != 0), "R9", "receive pending flag", rx_pend,
              fexp[28:24] != 0);
          fpend = 1'b0;
        end
        if (!spi_cs_n && in_ready) r10_bad++;
        if (sh_valid && spi_cs_n) r1_bad++;
        if (spi_cs_n && !prev_cs_n && bidx != 0) r1_bad++;
        prev_cs_n = spi_cs_n;
      end
      sh_ready = (cyc % 7) != 5;
      #1;
      if (!rst && sh_valid && sh_ready) begin
        if (bidx < 64) sh_rx = 8'(bidx) ^ 8'h5A;
        else           sh_rx = ref_footer(got_chunks)[8*(67-bidx) +: 8];
        got[bidx] = sh_data;
        bidx++;
        if (bidx == 68) begin
          logic [31:0] gh;
          logic [31:0] eh;
          int bad;
          bidx = 0;
          if (exp_q.size() < 68) begin
            chk(1'b0, "R7", "chunk sent with no expected frame", got_chunks, exp_chunks);
          end else begin
            for (int i = 0; i < 68; i++) e[i] = exp_q.pop_front();
            gh = {got[0], got[1], got[2], got[3]};
            eh = {e[0], e[1], e[2], e[3]};
            chk((gh & 32'hFFEF_8000) == (eh & 32'hFFEF_8000) && (gh[7:1] == 0), "R2",
                "header fixed bits", gh, eh);
            chk(gh[20] == eh[20], "R3", "start flag", gh[20], eh[20]);
            chk(gh[14:8] == eh[14:8], "R4", "end flag and offset", gh[14:8], eh[14:8]);
            chk($countones(gh) % 2 == 1, "R5", "header parity", gh, eh);
            if (eh[20] && eh[14])
              chk(gh[20] && gh[14], "R11", "single chunk flags", gh[20:14], eh[20:14]);
            bad = -1;
            for (int i = 4; i < 68; i++) if (bad < 0 && got[i] != e[i]) bad = i;
            chk(bad < 0, "R6", "payload byte", bad < 0 ? 0 : got[bad],
                bad < 0 ? 0 : e[bad]);
          end
          fexp  = ref_footer(got_chunks);
          fpend = 1'b1;
          got_chunks++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", got_chunks, exp_chunks);
    report();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(spi_cs_n == 1'b1, "R12", "chip select after reset", spi_cs_n, 1);
    chk(!in_ready && !sh_valid, "R12", "handshakes after reset", {in_ready, sh_valid}, 0);
    chk(!footer_vld && !rx_pend, "R12", "footer strobes after reset",
        {footer_vld, rx_pend}, 0);

    send_frame(0, 1, 1);      // R11 shortest frame
    send_frame(1, 64, 1);     // R11 full single chunk, offset 63
    send_frame(2, 65, 2);     // R4 one-byte tail chunk
    send_frame(3, 130, 5);    // R6 three chunks, padded tail
    send_frame(4, 200, 3);    // R7 one credit short, dropped
    send_frame(5, 100, 2);    // R7 exactly enough credits
    send_frame(6, 10, 0);     // R7 no credits, dropped
    send_frame(7, 128, 2);    // R4 tail fills the chunk
    send_frame(8, 3, 255);    // R6 short frame after drops

    for (int w = 0; w < 3000 && (exp_q.size() != 0 || !spi_cs_n); w++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(got_chunks == exp_chunks, "R7", "chunk count after drops", got_chunks, exp_chunks);
    chk(exp_q.size() == 0, "R6", "expected bytes left unsent", exp_q.size(), 0);
    chk(r10_bad == 0, "R10", "input ready during chunk", r10_bad, 0);
    chk(r1_bad == 0, "R1", "chip select framing errors", r1_bad, 0);
    report();
  end

endmodule